// File: doc/BRIEF.md
# Memory Operand Form Decoder

This block turns the addressing bytes of a variable-length instruction into a decoded operand description. It takes the mode/register/operand byte and the optional scale/index/base byte that may follow it. It also takes the three register-extension bits of the 64-bit prefix and the effective address size. From these it reports:

- whether the scale/index/base byte is needed;
- the register operand number;
- for a register-direct form, the second register;
- for a memory form, the base and index registers with their valid flags, the scale code, the displacement length in bytes, and whether the address is relative to the instruction pointer.

The block does not fetch bytes, compute addresses or read registers. The front end presents both bytes together with `valid_i`. The scale/index/base byte may hold any value when it is not needed. Parameter `REGISTERED` selects the timing: at 1 the outputs appear one clock after the inputs, and at 0 the block is purely combinational with `valid_o` following `valid_i`. All register numbers are 4-bit general-purpose register codes, with 0=AX, 3=BX, 5=BP, 6=SI and 7=DI.

Top module: `addr_form_dec`

## Requirements
- R1: The first byte is split as mode = bits 7:6, register field = bits 5:3 and operand field = bits 2:0. `reg_o` = {ext_r, register field}, and ext_r is treated as 0 unless the address size is 64-bit.
- R2: Mode 11 is a register-direct form. `rm_reg_o` = {ext_b, operand field}, with `is_mem_o`, `need_sib_o`, `base_vld_o`, `idx_vld_o` and `rip_rel_o` all 0, and `disp_len_o` = 0.
- R3: With 16-bit addressing and a memory mode, operand codes 0 to 7 give these base/index pairs: BX+SI, BX+DI, BP+SI, BP+DI, SI alone, DI alone, BP alone and BX alone.
- R4: With 16-bit addressing, mode 01 gives a 1-byte displacement, mode 10 gives a 2-byte displacement, and mode 00 gives none. The scale/index/base byte is never needed in 16-bit addressing.
- R5: With 16-bit addressing, mode 00 with operand code 110 is a direct 2-byte displacement with no base and no index.
- R6: With 32/64-bit addressing and a memory mode, operand code 100 sets `need_sib_o`. Mode 01 gives a 1-byte displacement and mode 10 a 4-byte one. With no scale/index/base byte, the base is {ext_b, operand field} and there is no index.
- R7: With 32-bit addressing, mode 00 with operand code 101 is a direct 4-byte displacement with no base and `rip_rel_o` = 0.
- R8: With 64-bit addressing, mode 00 with operand code 101 sets `rip_rel_o` with a 4-byte displacement and no base, whatever ext_b is.
- R9: The second byte is split as scale = bits 7:6, index = bits 5:3 and base = bits 2:0. `scale_o` carries the scale code (factor 1 << code) whenever that byte is needed, and is 0 otherwise. The index is {ext_x, index}, and the code 0100 means there is no index. The base is {ext_b, base}.
- R10: When the scale/index/base byte is needed with mode 00 and its base field is 101, there is no base and the displacement is 4 bytes, whatever ext_b is.
- R11: Outside 64-bit addressing the ext_r, ext_x and ext_b inputs have no effect on any output.
- R12: `asize_i` codes are 0 = 16-bit, 1 = 32-bit and 2 = 64-bit, and code 3 behaves as 32-bit. Unused register fields read 0.
- R13: After reset `valid_o` is 0. With `REGISTERED` = 1, every output reflects the inputs of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input bytes are valid |
| asize_i | input | 2 | Effective address size code |
| modrm_i | input | 8 | Mode/register/operand byte |
| sib_i | input | 8 | Scale/index/base byte (don't care when not needed) |
| rex_r_i | input | 1 | Register field extension bit |
| rex_x_i | input | 1 | Index extension bit |
| rex_b_i | input | 1 | Operand/base extension bit |
| valid_o | output | 1 | Decoded result valid |
| need_sib_o | output | 1 | Scale/index/base byte is required |
| is_mem_o | output | 1 | Operand is in memory |
| reg_o | output | 4 | Register operand number |
| rm_reg_o | output | 4 | Second register (register-direct form only) |
| base_vld_o | output | 1 | A base register is used |
| base_o | output | 4 | Base register number |
| idx_vld_o | output | 1 | An index register is used |
| idx_o | output | 4 | Index register number |
| scale_o | output | 2 | Scale code, factor 1 << code |
| disp_len_o | output | 3 | Displacement length in bytes (0, 1, 2 or 4) |
| rip_rel_o | output | 1 | Address is relative to the instruction pointer |

## Verification
The assertions only check cycles where `valid_i` is high. They assume the address size code stays stable in that cycle and that the scale/index/base byte may be arbitrary. They also take it that no pipeline history exists before reset. The stimulus releases reset before raising `valid_i`, and it changes inputs only on the falling edge. A sweep covers every first-byte value under all four size codes and all eight extension-bit combinations. In that sweep the second byte varies pseudo-randomly, so both its don't-care use and its decoded use stay inside what the checks assume.

// File: rtl/afd_pkg.sv
package afd_pkg;
  localparam int unsigned REG_W  = 4;
  localparam int unsigned DISP_W = 3;

  typedef enum logic [1:0] {
    ASZ_16  = 2'd0,
    ASZ_32  = 2'd1,
    ASZ_64  = 2'd2,
    ASZ_RSV = 2'd3
  } asize_e;

  // register codes used by the 16-bit table
  localparam logic [REG_W-1:0] GPR_BX = 4'd3;
  localparam logic [REG_W-1:0] GPR_BP = 4'd5;
  localparam logic [REG_W-1:0] GPR_SI = 4'd6;
  localparam logic [REG_W-1:0] GPR_DI = 4'd7;

  typedef struct packed {
    logic              need_sib;
    logic              is_mem;
    logic [REG_W-1:0]  reg_num;
    logic [REG_W-1:0]  rm_reg;
    logic              base_vld;
    logic [REG_W-1:0]  base;
    logic              idx_vld;
    logic [REG_W-1:0]  idx;
    logic [1:0]        scale;
    logic [DISP_W-1:0] disp_len;
    logic              rip_rel;
  } dec_t;
endpackage

// File: rtl/afd_mem16.sv
module afd_mem16
  import afd_pkg::*;
(
  input  logic [1:0]        mod_i,
  input  logic [2:0]        rm_i,
  output logic              base_vld_o,
  output logic [REG_W-1:0]  base_o,
  output logic              idx_vld_o,
  output logic [REG_W-1:0]  idx_o,
  output logic [DISP_W-1:0] disp_len_o
);
  logic direct;
  assign direct = (mod_i == 2'b00) && (rm_i == 3'b110);

  always_comb begin
    base_vld_o = 1'b1;
    idx_vld_o  = 1'b0;
    idx_o      = '0;
    base_o     = '0;
    unique case (rm_i)
      3'd0: begin base_o = GPR_BX; idx_vld_o = 1'b1; idx_o = GPR_SI; end
      3'd1: begin base_o = GPR_BX; idx_vld_o = 1'b1; idx_o = GPR_DI; end
      3'd2: begin base_o = GPR_BP; idx_vld_o = 1'b1; idx_o = GPR_SI; end
      3'd3: begin base_o = GPR_BP; idx_vld_o = 1'b1; idx_o = GPR_DI; end
      3'd4: base_o = GPR_SI;
      3'd5: base_o = GPR_DI;
      3'd6: base_o = GPR_BP;
      default: base_o = GPR_BX;
    endcase
    if (direct) begin
      base_vld_o = 1'b0;
      base_o     = '0;
    end
  end

  always_comb begin
    unique case (mod_i)
      2'b01:   disp_len_o = DISP_W'(1);
      2'b10:   disp_len_o = DISP_W'(2);
      default: disp_len_o = direct ? DISP_W'(2) : '0;
    endcase
  end
endmodule

// File: rtl/afd_mem3264.sv
module afd_mem3264
  import afd_pkg::*;
(
  input  logic [1:0]        mod_i,
  input  logic [2:0]        rm_i,
  input  logic [7:0]        sib_i,
  input  logic              ext_x_i,
  input  logic              ext_b_i,
  input  logic              long_i,
  output logic              need_sib_o,
  output logic              base_vld_o,
  output logic [REG_W-1:0]  base_o,
  output logic              idx_vld_o,
  output logic [REG_W-1:0]  idx_o,
  output logic [1:0]        scale_o,
  output logic [DISP_W-1:0] disp_len_o,
  output logic              rip_rel_o
);
  localparam logic [2:0] RM_ESC   = 3'b100;
  localparam logic [2:0] RM_NOBAS = 3'b101;

  logic [1:0] s_scale;
  logic [2:0] s_idx, s_base;
  logic       no_base;
  logic [REG_W-1:0] x_idx;

  assign {s_scale, s_idx, s_base} = sib_i;
  assign need_sib_o = (rm_i == RM_ESC);
  assign x_idx      = {ext_x_i, s_idx};

  // base suppressed: direct/rip form or escape with base code 101 in mode 00
  assign no_base = (mod_i == 2'b00) &&
                   (need_sib_o ? (s_base == RM_NOBAS) : (rm_i == RM_NOBAS));

  assign rip_rel_o  = long_i && (mod_i == 2'b00) && (rm_i == RM_NOBAS);
  assign scale_o    = need_sib_o ? s_scale : 2'b00;
  assign idx_vld_o  = need_sib_o && (x_idx != 4'b0100);
  assign idx_o      = idx_vld_o ? x_idx : '0;
  assign base_vld_o = !no_base;

  always_comb begin
    if (no_base)         base_o = '0;
    else if (need_sib_o) base_o = {ext_b_i, s_base};
    else                 base_o = {ext_b_i, rm_i};
  end

  always_comb begin
    unique case (mod_i)
      2'b01:   disp_len_o = DISP_W'(1);
      2'b10:   disp_len_o = DISP_W'(4);
      default: disp_len_o = no_base ? DISP_W'(4) : '0;
    endcase
  end
endmodule

// File: rtl/afd_stage.sv
module afd_stage
  import afd_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  dec_t dec_i,
  output logic valid_o,
  output dec_t dec_o
);
  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_o <= 1'b0;
          dec_o   <= '0;
        end else begin
          valid_o <= valid_i;
          dec_o   <= dec_i;
        end
      end
    end else begin : g_comb
      assign valid_o = valid_i;
      assign dec_o   = dec_i;
    end
  endgenerate
endmodule

// File: rtl/addr_form_dec.sv
module addr_form_dec
  import afd_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        asize_i,
  input  logic [7:0]        modrm_i,
  input  logic [7:0]        sib_i,
  input  logic              rex_r_i,
  input  logic              rex_x_i,
  input  logic              rex_b_i,
  output logic              valid_o,
  output logic              need_sib_o,
  output logic              is_mem_o,
  output logic [REG_W-1:0]  reg_o,
  output logic [REG_W-1:0]  rm_reg_o,
  output logic              base_vld_o,
  output logic [REG_W-1:0]  base_o,
  output logic              idx_vld_o,
  output logic [REG_W-1:0]  idx_o,
  output logic [1:0]        scale_o,
  output logic [DISP_W-1:0] disp_len_o,
  output logic              rip_rel_o
);
  asize_e     asz;
  logic       is16, is64;
  logic       ext_r, ext_x, ext_b;
  logic [1:0] f_mod;
  logic [2:0] f_reg, f_rm;
  logic       reg_form;

  assign asz      = asize_e'(asize_i);
  assign is16     = (asz == ASZ_16);
  assign is64     = (asz == ASZ_64);
  assign ext_r    = rex_r_i & is64;
  assign ext_x    = rex_x_i & is64;
  assign ext_b    = rex_b_i & is64;
  assign {f_mod, f_reg, f_rm} = modrm_i;
  assign reg_form = (f_mod == 2'b11);

  // 16-bit table
  logic              m16_bv, m16_iv;
  logic [REG_W-1:0]  m16_b, m16_i;
  logic [DISP_W-1:0] m16_d;

  afd_mem16 u_m16 (
    .mod_i      (f_mod),
    .rm_i       (f_rm),
    .base_vld_o (m16_bv),
    .base_o     (m16_b),
    .idx_vld_o  (m16_iv),
    .idx_o      (m16_i),
    .disp_len_o (m16_d)
  );

  // 32/64-bit forms
  logic              mw_sib, mw_bv, mw_iv, mw_rip;
  logic [REG_W-1:0]  mw_b, mw_i;
  logic [1:0]        mw_s;
  logic [DISP_W-1:0] mw_d;

  afd_mem3264 u_mw (
    .mod_i      (f_mod),
    .rm_i       (f_rm),
    .sib_i      (sib_i),
    .ext_x_i    (ext_x),
    .ext_b_i    (ext_b),
    .long_i     (is64),
    .need_sib_o (mw_sib),
    .base_vld_o (mw_bv),
    .base_o     (mw_b),
    .idx_vld_o  (mw_iv),
    .idx_o      (mw_i),
    .scale_o    (mw_s),
    .disp_len_o (mw_d),
    .rip_rel_o  (mw_rip)
  );

  dec_t dec;

  always_comb begin
    dec         = '0;
    dec.reg_num = {ext_r, f_reg};
    if (reg_form) begin
      dec.rm_reg = {ext_b, f_rm};
    end else if (is16) begin
      dec.is_mem   = 1'b1;
      dec.base_vld = m16_bv;
      dec.base     = m16_b;
      dec.idx_vld  = m16_iv;
      dec.idx      = m16_i;
      dec.disp_len = m16_d;
    end else begin
      dec.is_mem   = 1'b1;
      dec.need_sib = mw_sib;
      dec.base_vld = mw_bv;
      dec.base     = mw_b;
      dec.idx_vld  = mw_iv;
      dec.idx      = mw_i;
      dec.scale    = mw_s;
      dec.disp_len = mw_d;
      dec.rip_rel  = mw_rip;
    end
  end

  dec_t dec_q;

  afd_stage #(.REGISTERED(REGISTERED)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .dec_i   (dec),
    .valid_o (valid_o),
    .dec_o   (dec_q)
  );

  assign need_sib_o = dec_q.need_sib;
  assign is_mem_o   = dec_q.is_mem;
  assign reg_o      = dec_q.reg_num;
  assign rm_reg_o   = dec_q.rm_reg;
  assign base_vld_o = dec_q.base_vld;
  assign base_o     = dec_q.base;
  assign idx_vld_o  = dec_q.idx_vld;
  assign idx_o      = dec_q.idx;
  assign scale_o    = dec_q.scale;
  assign disp_len_o = dec_q.disp_len;
  assign rip_rel_o  = dec_q.rip_rel;

  assert_reg_ext_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is64) |-> (dec.reg_num[3] == 1'b0));

  assert_reg_form_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && reg_form) |-> (!dec.is_mem && !dec.base_vld && !dec.idx_vld &&
                               dec.disp_len == '0 && !dec.need_sib));

  assert_no_sib16_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is16) |-> !dec.need_sib);

  assert_disp16_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is16 && f_mod == 2'b10) |-> (dec.disp_len == DISP_W'(2)));

  assert_rip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dec.rip_rel) |-> (is64 && f_mod == 2'b00 &&
                                  dec.disp_len == DISP_W'(4) && !dec.base_vld));

  assert_nobase_disp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dec.is_mem && !dec.base_vld && !is16) |-> (dec.disp_len == DISP_W'(4)));
endmodule

// File: tb/tb_addr_form_dec.sv
`timescale 1ns/1ps
module tb_addr_form_dec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [1:0] asize = 2'd0;
  logic [7:0] modrm = 8'h00, sib = 8'h00;
  logic       rr = 1'b0, rx = 1'b0, rb = 1'b0;

  logic       valid_o, need_sib, is_mem, base_vld, idx_vld, rip_rel;
  logic [3:0] reg_o, rm_reg, base, idx;
  logic [1:0] scale;
  logic [2:0] disp_len;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addr_form_dec dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .asize_i(asize),
    .modrm_i(modrm), .sib_i(sib), .rex_r_i(rr), .rex_x_i(rx), .rex_b_i(rb),
    .valid_o(valid_o), .need_sib_o(need_sib), .is_mem_o(is_mem), .reg_o(reg_o),
    .rm_reg_o(rm_reg), .base_vld_o(base_vld), .base_o(base), .idx_vld_o(idx_vld),
    .idx_o(idx), .scale_o(scale), .disp_len_o(disp_len), .rip_rel_o(rip_rel)
  );

  // expected fields packed as one vector:
  // {need_sib, is_mem, reg, rm_reg, base_vld, base, idx_vld, idx, scale, disp, rip}
  function automatic logic [28:0] model(input int as, input int mb, input int sb,
                                        input int r, input int x, input int b);
    int m = mb / 64, rg = (mb / 8) % 8, rm = mb % 8;
    bit long = (as == 2), short = (as == 0);
    int er = long ? r : 0, ex = long ? x : 0, eb = long ? b : 0;
    int e_sib = 0, e_mem = 0, e_rmr = 0, e_bv = 0, e_b = 0, e_iv = 0, e_i = 0;
    int e_sc = 0, e_d = 0, e_rip = 0;
    int ix;
    if (m == 3) e_rmr = eb * 8 + rm;
    else begin
      e_mem = 1;
      if (short) begin
        int bases[8] = '{3, 3, 5, 5, 6, 7, 5, 3};
        int idxs[8]  = '{6, 7, 6, 7, 0, 0, 0, 0};
        e_bv = 1; e_b = bases[rm];
        if (rm < 4) begin e_iv = 1; e_i = idxs[rm]; end
        e_d = (m == 1) ? 1 : (m == 2) ? 2 : 0;
        if (m == 0 && rm == 6) begin e_bv = 0; e_b = 0; e_d = 2; end
      end else begin
        e_d = (m == 1) ? 1 : (m == 2) ? 4 : 0;
        if (rm == 4) begin
          e_sib = 1; e_sc = sb / 64;
          ix = ex * 8 + (sb / 8) % 8;
          if (ix != 4) begin e_iv = 1; e_i = ix; end
          if (m == 0 && sb % 8 == 5) e_d = 4;
          else begin e_bv = 1; e_b = eb * 8 + sb % 8; end
        end else if (m == 0 && rm == 5) begin
          e_d = 4; e_rip = long ? 1 : 0;
        end else begin
          e_bv = 1; e_b = eb * 8 + rm;
        end
      end
    end
    return {e_sib[0], e_mem[0], 4'(er * 8 + rg), 4'(e_rmr), e_bv[0], 4'(e_b),
            e_iv[0], 4'(e_i), 2'(e_sc), 3'(e_d), e_rip[0]};
  endfunction

  task automatic check(input string tag, input logic [28:0] act, input logic [28:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s asize=%0d modrm=%h sib=%h rex=%0d%0d%0d act=%h exp=%h",
               tag, asize, modrm, sib, rr, rx, rb, act, exp);
    end
  endtask

  task automatic apply(input string tag, input int as, input int mb, input int sb,
                       input int r, input int x, input int b);
    @(negedge clk);
    valid_i = 1'b1; asize = 2'(as); modrm = 8'(mb); sib = 8'(sb);
    rr = r[0]; rx = x[0]; rb = b[0];
    @(posedge clk); #2;
    check(tag, {need_sib, is_mem, reg_o, rm_reg, base_vld, base, idx_vld, idx,
                scale, disp_len, rip_rel}, model(as, mb, sb, r, x, b));
    n_run++;
    if (valid_o !== 1'b1) begin
      n_fail++;
      $display("FAIL R13 valid_o act=%b exp=1", valid_o);
    end
  endtask

  function automatic string sweep_tag(input int as, input int mb);
    if (mb / 64 == 3) return "R2";
    if (as == 0) return "R3";
    if (as == 3) return "R12";
    if (mb % 8 == 4) return "R9";
    return "R6";
  endfunction

  initial begin
    #2;
    n_run++;
    if (valid_o !== 1'b0) begin n_fail++; $display("FAIL R13 reset valid_o act=%b exp=0", valid_o); end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    n_run++;
    if (valid_o !== 1'b0) begin n_fail++; $display("FAIL R13 idle valid_o act=%b exp=0", valid_o); end

    apply("R1",  2, 8'b00_101_011, 0, 1, 0, 0);   // reg = 13
    apply("R1",  1, 8'b00_101_011, 0, 1, 0, 0);   // ext_r ignored in 32-bit
    apply("R2",  2, 8'hD0, 0, 0, 0, 1);           // rm_reg = 8
    apply("R3",  0, 8'h02, 0, 0, 0, 0);           // BP+SI
    apply("R4",  0, 8'h56, 0, 0, 0, 0);           // BP + disp8
    apply("R4",  0, 8'h97, 0, 0, 0, 0);           // BX + disp16
    apply("R5",  0, 8'h06, 0, 0, 0, 0);           // direct disp16
    apply("R6",  1, 8'h44, 8'h4B, 0, 0, 0);       // sib, disp8
    apply("R6",  2, 8'h83, 0, 0, 0, 1);           // base 11, disp32
    apply("R7",  1, 8'h05, 0, 0, 0, 0);           // direct disp32
    apply("R8",  2, 8'h05, 0, 0, 0, 1);           // rip-rel, B ignored
    apply("R9",  2, 8'h04, 8'h1B, 0, 1, 0);       // index 11
    apply("R9",  2, 8'h04, 8'h24, 0, 1, 1);       // index 12 valid
    apply("R9",  2, 8'h04, 8'hE4, 0, 0, 0);       // no index, scale 3
    apply("R10", 2, 8'h04, 8'h0D, 0, 0, 1);       // no base, disp32
    apply("R10", 2, 8'h44, 8'h0D, 0, 0, 1);       // mode 01: base 13
    apply("R11", 1, 8'h04, 8'h24, 1, 1, 1);       // ext bits ignored
    apply("R11", 0, 8'hC7, 0, 1, 1, 1);
    apply("R12", 3, 8'h05, 0, 1, 1, 1);           // code 3 as 32-bit

    @(negedge clk); valid_i = 1'b0;
    @(posedge clk); #2;
    n_run++;
    if (valid_o !== 1'b0) begin n_fail++; $display("FAIL R13 valid drop act=%b exp=0", valid_o); end

    for (int as = 0; as < 4; as++)
      for (int mb = 0; mb < 256; mb++)
        for (int rex = 0; rex < 8; rex++)
          apply(sweep_tag(as, mb), as, mb, (mb * 37 + rex * 91 + as * 13) % 256,
                rex / 4, (rex / 2) % 2, rex % 2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule